// File: doc/BRIEF.md
# Outbound Window Address Translator

This block maps local bus addresses that fall inside a fixed local aperture onto a wider 64-bit remote address space. The aperture is divided into a row of equal windows. A small size code, shared by every window, selects the window size as a power of two megabytes. Each window has its own 64-bit remote base, split into a low word and a high word. Bit 0 of the low word is that window's enable. A master enable bit in a command register turns the whole translation function on or off.

Translation requests arrive on a valid/ready stream and leave on a second valid/ready stream. Each response carries the 64-bit output address and a hit flag. The response stage is a single register. A request is accepted only while that register is empty or is being emptied in the same cycle, so back-pressure on the response side reaches the request side with no delay. Any address that cannot be translated is returned unchanged and zero-extended, with the hit flag low.

Software programs the block through a plain register port. Writes take effect at the clock edge. Read data appears one cycle after the read strobe.

Top module: `ob_xlate_win`

## Requirements
- R1: After reset every register reads as zero and `rsp_valid` is low.
- R2: A read returns the last value written to that register one cycle after `reg_rd_en`. The command register is at 0x004 and keeps all 32 bits. The size register is at 0x030 and keeps only bits [2:0]. Window i has its low word at 0x200+8*i and its high word at 0x204+8*i. Writes to any other address are dropped, and reads of any other address return zero.
- R3: Size code N gives a window size of 2^(20+N) bytes. For an address A, the window index is (A − APER_BASE) >> (20+N).
- R4: On a hit, the output is the 64-bit value {high word, low word with bit 0 cleared} plus the address bits below the window size. The full 64-bit addition is carried out, and `rsp_hit` is 1.
- R5: A window whose low-word bit 0 is 0 does not translate. Its addresses pass through with `rsp_hit` 0.
- R6: While command-register bit 1 is 0, no address is translated.
- R7: An address below APER_BASE, or one whose window index is NUM_WIN or higher, passes through with `rsp_hit` 0.
- R8: A pass-through response carries the local address, zero-extended to 64 bits.
- R9: The response becomes valid in the cycle after the request is accepted. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `req_ready` stays low.
- R10: A request accepted in the same cycle as a register write is translated with the register values that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request address is offered |
| req_ready | output | 1 | The block can accept a request |
| req_addr | input | LA_W | Local address to translate |
| rsp_valid | output | 1 | A response is held |
| rsp_ready | input | 1 | The consumer takes the response |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_hit | output | 1 | 1 when a window translated the address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | RA_W | Register write byte address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | RA_W | Register read byte address |
| reg_rd_data | output | 32 | Read data, valid the cycle after the strobe |

## Verification
A register write and a translation request can land on the same clock edge. The bench provokes this by driving a write to a window's low word together with a request that falls inside that window, on the same falling edge. It judges the result by expecting the old remote base in that response and the new base in the next request. Back-pressure is checked separately: the bench holds `rsp_ready` low for several cycles and confirms that the response does not move and that no new request is accepted.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int MB_SHIFT    = 20;
  localparam int XLAT_EN_BIT = 1;
  localparam logic [11:0] CMD_OFS  = 12'h004;
  localparam logic [11:0] SIZE_OFS = 12'h030;
  localparam logic [11:0] WIN_OFS  = 12'h200;

  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
  } win_t;
endpackage

// File: rtl/obx_regfile.sv
module obx_regfile
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int RA_W    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [RA_W-1:0]           wr_addr,
  input  logic [31:0]               wr_data,
  input  logic                      rd_en,
  input  logic [RA_W-1:0]           rd_addr,
  output logic [31:0]               rd_data,
  output logic                      xlat_on,
  output logic [2:0]                size_code,
  output win_t [NUM_WIN-1:0]        wins
);
  localparam logic [RA_W-1:0] CMD_A  = RA_W'(CMD_OFS);
  localparam logic [RA_W-1:0] SIZE_A = RA_W'(SIZE_OFS);

  logic [31:0] cmd_q;
  logic [2:0]  size_q;
  logic [31:0] rd_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      size_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == CMD_A)  cmd_q  <= wr_data;
      if (wr_addr == SIZE_A) size_q <= wr_data[2:0];
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam logic [RA_W-1:0] LO_A = RA_W'(WIN_OFS) + RA_W'(8 * i);
    localparam logic [RA_W-1:0] HI_A = LO_A + RA_W'(4);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wins[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == LO_A) wins[i].lo <= wr_data;
        if (wr_addr == HI_A) wins[i].hi <= wr_data;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == CMD_A)  rd_next = cmd_q;
    if (rd_addr == SIZE_A) rd_next = {29'd0, size_q};
    for (int i = 0; i < NUM_WIN; i++) begin
      if (rd_addr == RA_W'(WIN_OFS) + RA_W'(8 * i))     rd_next = wins[i].lo;
      if (rd_addr == RA_W'(WIN_OFS) + RA_W'(8 * i + 4)) rd_next = wins[i].hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assign xlat_on   = cmd_q[XLAT_EN_BIT];
  assign size_code = size_q;
endmodule

// File: rtl/obx_lookup.sv
module obx_lookup
  import obx_pkg::*;
#(
  parameter int          NUM_WIN   = 32,
  parameter int          LA_W      = 32,
  parameter logic [31:0] APER_BASE = 32'h4000_0000
) (
  input  logic [LA_W-1:0]     local_addr,
  input  logic                xlat_on,
  input  logic [2:0]          size_code,
  input  win_t [NUM_WIN-1:0]  wins,
  output logic [63:0]         xaddr,
  output logic                hit
);
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam logic [LA_W-1:0] BASE = LA_W'(APER_BASE);

  logic [5:0]      shift;
  logic [LA_W-1:0] offset;
  logic [LA_W-1:0] idx_full;
  logic [LA_W-1:0] in_mask;
  logic [IDX_W-1:0] idx;
  logic            below;
  logic            in_range;
  logic            win_on;
  logic [63:0]     rbase;

  always_comb begin
    shift    = 6'(MB_SHIFT) + {3'd0, size_code};
    below    = local_addr < BASE;
    offset   = local_addr - BASE;
    idx_full = offset >> shift;
    in_mask  = (LA_W'(1) << shift) - LA_W'(1);
    in_range = !below && (idx_full < LA_W'(NUM_WIN));
    idx      = idx_full[IDX_W-1:0];
    win_on   = 1'b0;
    rbase    = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (idx == IDX_W'(i)) begin
        win_on = wins[i].lo[0];
        rbase  = {wins[i].hi, wins[i].lo[31:1], 1'b0};
      end
    end
    hit   = xlat_on && in_range && win_on;
    xaddr = hit ? (rbase + 64'(offset & in_mask)) : 64'(local_addr);
  end
endmodule

// File: rtl/obx_outstage.sv
module obx_outstage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_addr,
  input  logic         in_hit,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_addr,
  output logic         out_hit
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_hit   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= in_addr;
        out_hit  <= in_hit;
      end
    end
  end
endmodule

// File: rtl/ob_xlate_win.sv
module ob_xlate_win
  import obx_pkg::*;
#(
  parameter int          NUM_WIN   = 32,
  parameter int          LA_W      = 32,
  parameter int          RA_W      = 12,
  parameter logic [31:0] APER_BASE = 32'h4000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [LA_W-1:0] req_addr,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [63:0]     rsp_addr,
  output logic            rsp_hit,
  input  logic            reg_wr_en,
  input  logic [RA_W-1:0] reg_wr_addr,
  input  logic [31:0]     reg_wr_data,
  input  logic            reg_rd_en,
  input  logic [RA_W-1:0] reg_rd_addr,
  output logic [31:0]     reg_rd_data
);
  logic               xlat_on;
  logic [2:0]         size_code;
  win_t [NUM_WIN-1:0] wins;
  logic [63:0]        lk_addr;
  logic               lk_hit;

  obx_regfile #(.NUM_WIN(NUM_WIN), .RA_W(RA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .rd_en     (reg_rd_en),
    .rd_addr   (reg_rd_addr),
    .rd_data   (reg_rd_data),
    .xlat_on   (xlat_on),
    .size_code (size_code),
    .wins      (wins)
  );

  obx_lookup #(.NUM_WIN(NUM_WIN), .LA_W(LA_W), .APER_BASE(APER_BASE)) u_lookup (
    .local_addr (req_addr),
    .xlat_on    (xlat_on),
    .size_code  (size_code),
    .wins       (wins),
    .xaddr      (lk_addr),
    .hit        (lk_hit)
  );

  obx_outstage #(.W(64)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_addr   (lk_addr),
    .in_hit    (lk_hit),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_addr  (rsp_addr),
    .out_hit   (rsp_hit)
  );
endmodule

// File: rtl/obx_chk.sv
module obx_chk #(
  parameter int LA_W = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_addr,
  input logic        rsp_hit,
  input logic        xlat_on
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  // R9
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_hit));

  // R6
  off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !xlat_on |=> !rsp_hit);

  // R8
  pass_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_addr[63:LA_W] == '0);
endmodule

bind ob_xlate_win obx_chk #(.LA_W(LA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_hit   (rsp_hit),
  .xlat_on   (xlat_on)
);

// File: tb/ob_xlate_win_bench.sv
`timescale 1ns/1ps
module ob_xlate_win_bench;
  localparam logic [31:0] AB = 32'h4000_0000;
  localparam logic [31:0] MB = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic        rsp_hit;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic        reg_rd_en = 1'b0;
  logic [11:0] reg_rd_addr = '0;
  logic [31:0] reg_rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ob_xlate_win u_ob_xlate_win (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_rd_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rd_data;
  endtask

  task automatic xl(logic [31:0] a, output logic [63:0] xa, output logic h);
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 response valid after accept", {63'd0, rsp_valid}, 64'd1);
    xa = rsp_addr; h = rsp_hit;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    rd(12'h004, d); check("R1 cmd reset", {32'd0, d}, 64'd0);
    rd(12'h030, d); check("R1 size reset", {32'd0, d}, 64'd0);
    rd(12'h200, d); check("R1 win0 lo reset", {32'd0, d}, 64'd0);
    rd(12'h2FC, d); check("R1 win31 hi reset", {32'd0, d}, 64'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(12'h004, 32'hA5A5_5A5A); rd(12'h004, d); check("R2 cmd readback", {32'd0, d}, 64'hA5A5_5A5A);
    wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, d); check("R2 size keeps 3 bits", {32'd0, d}, 64'd7);
    wr(12'h2F8, 32'h1234_5679); rd(12'h2F8, d); check("R2 win31 lo", {32'd0, d}, 64'h1234_5679);
    wr(12'h20C, 32'hDEAD_BEEF); rd(12'h20C, d); check("R2 win1 hi", {32'd0, d}, 64'hDEAD_BEEF);
    wr(12'h100, 32'hFFFF_FFFF); rd(12'h100, d); check("R2 unmapped reads zero", {32'd0, d}, 64'd0);
    rd(12'h004, d); check("R2 unmapped write leaves cmd", {32'd0, d}, 64'hA5A5_5A5A);
    wr(12'h2F8, 32'h0); wr(12'h20C, 32'h0); wr(12'h004, 32'h0);
  endtask

  task automatic t_basic();
    logic [63:0] xa; logic h;
    wr(12'h030, 32'd0);
    wr(12'h200, 32'h8000_0001); wr(12'h204, 32'h0000_0012);
    wr(12'h218, 32'h0010_0001); wr(12'h21C, 32'h0);
    wr(12'h004, 32'h2);
    xl(AB + 32'h1234, xa, h);
    check("R4 win0 address", xa, 64'h12_8000_1234); check("R4 win0 hit", {63'd0, h}, 64'd1);
    xl(AB + 3 * MB + 32'h55, xa, h);
    check("R3 win3 index 1MB", xa, 64'h0010_0055); check("R3 win3 hit", {63'd0, h}, 64'd1);
  endtask

  task automatic t_size();
    logic [63:0] xa; logic h;
    wr(12'h030, 32'd2);
    wr(12'h208, 32'hA000_0001); wr(12'h20C, 32'h3);
    xl(AB + 5 * MB, xa, h);
    check("R3 size code 2 selects win1", xa, 64'h3_A010_0000); check("R3 hit", {63'd0, h}, 64'd1);
    wr(12'h030, 32'd0);
  endtask

  task automatic t_carry();
    logic [63:0] xa; logic h;
    wr(12'h210, 32'hFFFF_0001); wr(12'h214, 32'h1);
    xl(AB + 2 * MB + 32'h2_0000, xa, h);
    check("R4 carry into high word", xa, 64'h2_0001_0000);
  endtask

  task automatic t_disabled();
    logic [63:0] xa; logic h;
    wr(12'h220, 32'h0050_0000);
    xl(AB + 4 * MB + 32'h8, xa, h);
    check("R5 disabled window no hit", {63'd0, h}, 64'd0);
    check("R8 disabled window passes", xa, {32'd0, AB + 4 * MB + 32'h8});
  endtask

  task automatic t_global_off();
    logic [63:0] xa; logic h;
    wr(12'h004, 32'h0);
    xl(AB + 32'h40, xa, h);
    check("R6 global off no hit", {63'd0, h}, 64'd0);
    check("R6 global off passes", xa, {32'd0, AB + 32'h40});
    wr(12'h004, 32'h2);
  endtask

  task automatic t_range();
    logic [63:0] xa; logic h;
    wr(12'h2F8, 32'h7000_0001);
    xl(AB + 32 * MB + 32'h4, xa, h);
    check("R7 past last window no hit", {63'd0, h}, 64'd0);
    check("R7 past last window passes", xa, {32'd0, AB + 32 * MB + 32'h4});
    xl(AB + 31 * MB + 32'h4, xa, h);
    check("R7 last window translates", xa, 64'h7000_0004);
    xl(AB - 32'h10, xa, h);
    check("R7 below base no hit", {63'd0, h}, 64'd0);
    check("R8 below base passes", xa, {32'd0, AB - 32'h10});
  endtask

  task automatic t_backpressure();
    logic [63:0] held;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = AB + 32'h77;
    @(negedge clk);
    held = rsp_addr;
    req_addr = AB + 32'h99;
    check("R9 valid under stall", {63'd0, rsp_valid}, 64'd1);
    check("R9 first response", held, 64'h12_8000_0077);
    repeat (3) @(negedge clk);
    check("R9 req_ready low under stall", {63'd0, req_ready}, 64'd0);
    check("R9 response held", rsp_addr, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next response after release", rsp_addr, 64'h12_8000_0099);
    @(negedge clk);
    check("R9 drained", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_same_cycle();
    logic [63:0] xa; logic h;
    wr(12'h228, 32'h1000_0001);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 12'h228; reg_wr_data = 32'h2000_0001;
    req_valid = 1'b1; req_addr = AB + 5 * MB + 32'h4; rsp_ready = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; req_valid = 1'b0;
    check("R10 same-cycle uses old base", rsp_addr, 64'h1000_0004);
    xl(AB + 5 * MB + 32'h4, xa, h);
    check("R10 next request uses new base", xa, 64'h2000_0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_size();
    t_carry();
    t_disabled();
    t_global_off();
    t_range();
    t_backpressure();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule